// File: doc/BRIEF.md
# DRAM Read Return Path with Strobe Accounting

This block sits beside a DRAM command engine. Each time the engine issues a read, it hands the block a one-cycle notice that carries the number of the bus port that asked for the data. The block holds that notice for a programmable number of cycles, which covers the memory's internal pipeline. It then samples a fixed number of data beats from the DQ bus, packs them into one wide word, and returns the word together with the requesting port number as a single-cycle valid pulse.

The block also keeps a running count of strobe groups that the memory still owes. Every issued read adds one to the count, and every strobe group reported by the capture logic removes one. Adding while the count is full, or removing while it is empty, sets a sticky error flag. Software clears a flag by writing a 1 to its bit. Each flag has an enable bit, and a flag whose enable is set drives the interrupt.

Read notices must be at least BEATS cycles apart, and the latency setting must stay unchanged while reads are in flight.

Top module: `rd_capture`

## Requirements
- R1: When a read notice is given in cycle t and the effective latency is L, beat 0 is sampled from `dq_in` in cycle t+L, and beat k is sampled in cycle t+L+k.
- R2: Exactly BEATS beats are collected per read. Beat k lands in bits [k*DATA_W +: DATA_W] of `rd_data`.
- R3: `rd_port` carries the `cmd_port` value that came with the read notice.
- R4: `rd_valid` is high for exactly one cycle, the cycle after the last beat is sampled, and stays low at all other times.
- R5: The effective latency is `lat_cfg` limited to the range 2 to 8. A value below 2 acts as 2, and a value above 8 acts as 8.
- R6: The outstanding-strobe count rises by one on `cmd_valid` and falls by one on `strb_grp`, and holds DEPTH at most. A notice that arrives while the count is full (with no strobe in the same cycle) leaves the count unchanged and sets the overflow flag. A strobe that arrives while the count is empty (with no notice in the same cycle) sets the underflow flag.
- R7: The flags are sticky. Writing 1 to `sts_clr[0]` clears overflow and writing 1 to `sts_clr[1]` clears underflow. A new error in the same cycle wins over the clear.
- R8: `irq` equals (overflow AND `irq_en[0]`) OR (underflow AND `irq_en[1]`).
- R9: After reset, `rd_valid`, both flags and `irq` are low and the strobe count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lat_cfg | input | LAT_CFG_W | Pipeline latency setting in cycles |
| cmd_valid | input | 1 | Read notice from the command engine |
| cmd_port | input | PORT_W | Requesting bus port of the read |
| dq_in | input | DATA_W | Captured read data beat |
| strb_grp | input | 1 | One strobe group arrived from the memory |
| irq_en | input | 2 | Interrupt enables: bit 0 overflow, bit 1 underflow |
| sts_clr | input | 2 | Write-1-to-clear: bit 0 overflow, bit 1 underflow |
| rd_valid | output | 1 | Assembled burst is valid in this cycle |
| rd_port | output | PORT_W | Port the burst belongs to |
| rd_data | output | BEATS*DATA_W | Assembled burst, beat 0 in the low bits |
| err_ovf | output | 1 | Sticky overflow flag |
| err_udf | output | 1 | Sticky underflow flag |
| irq | output | 1 | Masked error interrupt |

## Verification
A read given in cycle t produces `rd_valid` in cycle t+L+BEATS, with L being the effective latency. The bench presents beat k only during cycle t+L+k and drives a filler word at every other time, so a latency that is off by one cycle shows up as wrong data. The bench also checks that `rd_valid` is low before that cycle and low again in the cycle after it. The flags and the strobe count change at the edge that samples the event, so each flag is checked one cycle after its stimulus. `irq` has no register on its path, so it is checked in the same cycle that the enables change.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int MIN_LAT = 2;

  typedef enum int {
    FLG_OVF = 0,
    FLG_UDF = 1
  } flag_idx_e;

  function automatic int clamp_lat(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/rdc_lat_pipe.sv
module rdc_lat_pipe #(
  parameter int MAX_LAT = 8,
  parameter int PORT_W  = 2,
  parameter int LAT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PORT_W-1:0] in_port,
  input  logic [LAT_W-1:0]  lat_sel,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_port
);
  logic [MAX_LAT-1:0] vld_q, vld_d;
  logic [PORT_W-1:0]  prt_q [MAX_LAT];
  logic [PORT_W-1:0]  prt_d [MAX_LAT];

  always_comb begin
    vld_d[0] = in_valid;
    prt_d[0] = in_port;
    for (int i = 1; i < MAX_LAT; i++) begin
      vld_d[i] = vld_q[i-1];
      prt_d[i] = prt_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < MAX_LAT; i++) prt_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < MAX_LAT; i++) prt_q[i] <= prt_d[i];
    end
  end

  // tap: a token sits in stage lat_sel-1 during cycle t+lat_sel
  always_comb begin
    out_valid = 1'b0;
    out_port  = '0;
    for (int i = 0; i < MAX_LAT; i++) begin
      if (LAT_W'(i + 1) == lat_sel) begin
        out_valid = vld_q[i];
        out_port  = prt_q[i];
      end
    end
  end
endmodule

// File: rtl/rdc_beat_collect.sv
module rdc_beat_collect #(
  parameter int DATA_W = 16,
  parameter int BEATS  = 4,
  parameter int PORT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PORT_W-1:0]       start_port,
  input  logic [DATA_W-1:0]       dq_in,
  output logic                    done,
  output logic [PORT_W-1:0]       port,
  output logic [BEATS*DATA_W-1:0] data
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, slot;
  logic [PORT_W-1:0] port_q, port_d;
  logic              done_q, done_d;
  logic              wr;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    port_d = port_q;
    done_d = 1'b0;
    wr     = 1'b0;
    slot   = '0;
    if (busy_q) begin
      wr   = 1'b1;
      slot = cnt_q;
      if (cnt_q == CNT_W'(BEATS - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      wr     = 1'b1;
      port_d = start_port;
      if (BEATS == 1) begin
        done_d = 1'b1;
      end else begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      port_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      port_q <= port_d;
      done_q <= done_d;
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_slot
    logic [DATA_W-1:0] beat_q;
    logic              beat_en;
    assign beat_en = wr && (slot == CNT_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       beat_q <= '0;
      else if (beat_en) beat_q <= dq_in;
    end
    assign data[b*DATA_W +: DATA_W] = beat_q;
  end

  assign done = done_q;
  assign port = port_q;
endmodule

// File: rtl/rdc_strobe_track.sv
module rdc_strobe_track #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic [1:0] clr,
  output logic       full,
  output logic       empty,
  output logic       ovf,
  output logic       udf
);
  import rdc_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          ovf_set, udf_set;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    ovf_set = 1'b0;
    udf_set = 1'b0;
    unique case ({push, pop})
      2'b10: if (full)  ovf_set = 1'b1; else cnt_d = cnt_q + 1'b1;
      2'b01: if (empty) udf_set = 1'b1; else cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    ovf_d = ovf_set | (ovf_q & ~clr[FLG_OVF]);
    udf_d = udf_set | (udf_q & ~clr[FLG_UDF]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign ovf = ovf_q;
  assign udf = udf_q;
endmodule

// File: rtl/rd_capture.sv
module rd_capture #(
  parameter int DATA_W    = 16,
  parameter int BEATS     = 4,
  parameter int PORT_W    = 2,
  parameter int MAX_LAT   = 8,
  parameter int LAT_CFG_W = 4,
  parameter int DEPTH     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LAT_CFG_W-1:0]    lat_cfg,
  input  logic                    cmd_valid,
  input  logic [PORT_W-1:0]       cmd_port,
  input  logic [DATA_W-1:0]       dq_in,
  input  logic                    strb_grp,
  input  logic [1:0]              irq_en,
  input  logic [1:0]              sts_clr,
  output logic                    rd_valid,
  output logic [PORT_W-1:0]       rd_port,
  output logic [BEATS*DATA_W-1:0] rd_data,
  output logic                    err_ovf,
  output logic                    err_udf,
  output logic                    irq
);
  import rdc_pkg::*;

  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  logic [LAT_CFG_W-1:0] lat_sel;
  logic                 tap_valid;
  logic [PORT_W-1:0]    tap_port;
  logic                 fifo_full, fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    lat_sel = LAT_CFG_W'(clamp_lat(int'(lat_cfg), MIN_LAT, MAX_LAT));
  end

  rdc_lat_pipe #(.MAX_LAT(MAX_LAT), .PORT_W(PORT_W), .LAT_W(LAT_CFG_W)) u_pipe (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(cmd_valid), .in_port(cmd_port),
    .lat_sel(lat_sel), .out_valid(tap_valid), .out_port(tap_port)
  );

  rdc_beat_collect #(.DATA_W(DATA_W), .BEATS(BEATS), .PORT_W(PORT_W)) u_coll (
    .clk(clk), .rst_n(rst_sync_n), .start(tap_valid), .start_port(tap_port),
    .dq_in(dq_in), .done(rd_valid), .port(rd_port), .data(rd_data)
  );

  rdc_strobe_track #(.DEPTH(DEPTH)) u_strb (
    .clk(clk), .rst_n(rst_sync_n), .push(cmd_valid), .pop(strb_grp),
    .clr(sts_clr), .full(fifo_full), .empty(fifo_empty),
    .ovf(err_ovf), .udf(err_udf)
  );

  assign irq = (err_ovf & irq_en[FLG_OVF]) | (err_udf & irq_en[FLG_UDF]);
endmodule

// File: rtl/rd_capture_chk.sv
module rd_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       strb_grp,
  input logic [1:0] sts_clr,
  input logic [1:0] irq_en,
  input logic       rd_valid,
  input logic       err_ovf,
  input logic       err_udf,
  input logic       irq,
  input logic       fifo_full,
  input logic       fifo_empty
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && fifo_full && !strb_grp) |=> err_ovf); // R6
  AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_grp && fifo_empty && !cmd_valid) |=> err_udf); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovf && !sts_clr[0]) |=> err_ovf); // R7
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_udf && !sts_clr[1]) |=> err_udf); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_ovf && !err_udf) || (irq_en == 2'b00) |-> !irq); // R8
  AST_NOT_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R6
endmodule

bind rd_capture rd_capture_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .strb_grp(strb_grp),
  .sts_clr(sts_clr), .irq_en(irq_en), .rd_valid(rd_valid), .err_ovf(err_ovf),
  .err_udf(err_udf), .irq(irq), .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/sim_rd_capture.sv
module sim_rd_capture;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int PW = 2;
  localparam int DEPTH = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [3:0]      lat_cfg;
  logic            cmd_valid;
  logic [PW-1:0]   cmd_port;
  logic [DW-1:0]   dq_in;
  logic            strb_grp;
  logic [1:0]      irq_en, sts_clr;
  logic            rd_valid;
  logic [PW-1:0]   rd_port;
  logic [NB*DW-1:0] rd_data;
  logic            err_ovf, err_udf, irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rd_capture u0 (
    .clk(clk), .rst_n(rst_n), .lat_cfg(lat_cfg), .cmd_valid(cmd_valid),
    .cmd_port(cmd_port), .dq_in(dq_in), .strb_grp(strb_grp), .irq_en(irq_en),
    .sts_clr(sts_clr), .rd_valid(rd_valid), .rd_port(rd_port), .rd_data(rd_data),
    .err_ovf(err_ovf), .err_udf(err_udf), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one read: notice in cycle t, beats driven only in cycles t+L .. t+L+NB-1
  task automatic do_read(input logic [PW-1:0] p, input logic [3:0] cfg,
                         input int eff, input logic [DW-1:0] base, input string req);
    logic [NB*DW-1:0] exp;
    for (int k = 0; k < NB; k++) exp[k*DW +: DW] = base + DW'(k);
    @(negedge clk);
    lat_cfg = cfg; cmd_valid = 1'b1; cmd_port = p;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (eff - 1) @(posedge clk);
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      dq_in = base + DW'(k);
      chk({req, " R4 early"}, 64'(rd_valid), 64'd0);
      @(posedge clk);
    end
    @(negedge clk);
    dq_in = 16'hDEAD;
    chk({req, " R4 valid"}, 64'(rd_valid), 64'd1);
    chk({req, " R3 port"}, 64'(rd_port), 64'(p));
    chk({req, " R1 R2 data"}, 64'(rd_data), 64'(exp));
    @(negedge clk);
    chk({req, " R4 single"}, 64'(rd_valid), 64'd0);
    strb_grp = 1'b1;
    @(negedge clk);
    strb_grp = 1'b0;
    chk({req, " R6 drained"}, 64'({err_ovf, err_udf}), 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; lat_cfg = 4'd2; cmd_valid = 1'b0; cmd_port = '0;
    dq_in = 16'hDEAD; strb_grp = 1'b0; irq_en = 2'b00; sts_clr = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 rd_valid", 64'(rd_valid), 64'd0);
    chk("R9 flags", 64'({err_ovf, err_udf}), 64'd0);
    chk("R9 irq", 64'(irq), 64'd0);
  endtask

  task automatic t_reads;
    do_read(2'd1, 4'd2, 2, 16'h1000, "lat2");
    do_read(2'd2, 4'd8, 8, 16'h2200, "lat8");
    do_read(2'd3, 4'd5, 5, 16'h3300, "lat5");
  endtask

  task automatic t_clamp;
    do_read(2'd0, 4'd0, 2, 16'h4400, "R5 low");
    do_read(2'd2, 4'd15, 8, 16'h5500, "R5 high");
  endtask

  task automatic t_overflow;
    for (int n = 0; n <= DEPTH; n++) begin
      @(negedge clk);
      lat_cfg = 4'd2; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R6 ovf", 64'(err_ovf), (n == DEPTH) ? 64'd1 : 64'd0);
      repeat (NB + 2) @(negedge clk);
    end
    chk("R8 masked", 64'(irq), 64'd0);
    irq_en = 2'b10;
    #1 chk("R8 wrong enable", 64'(irq), 64'd0);
    irq_en = 2'b01;
    #1 chk("R8 ovf irq", 64'(irq), 64'd1);
    repeat (3) @(negedge clk);
    chk("R7 sticky", 64'(err_ovf), 64'd1);
    sts_clr = 2'b10;
    @(negedge clk);
    sts_clr = 2'b00;
    chk("R7 other bit ignored", 64'(err_ovf), 64'd1);
    sts_clr = 2'b01;
    @(negedge clk);
    sts_clr = 2'b00;
    chk("R7 ovf cleared", 64'(err_ovf), 64'd0);
    chk("R8 irq low", 64'(irq), 64'd0);
    irq_en = 2'b00;
  endtask

  task automatic t_underflow;
    // count is DEPTH after the overflow test: DEPTH pops are legal
    for (int n = 0; n <= DEPTH; n++) begin
      @(negedge clk);
      strb_grp = 1'b1;
      @(negedge clk);
      strb_grp = 1'b0;
      chk("R6 udf", 64'(err_udf), (n == DEPTH) ? 64'd1 : 64'd0);
    end
    irq_en = 2'b10;
    #1 chk("R8 udf irq", 64'(irq), 64'd1);
    // clear together with a new underflow: set wins
    @(negedge clk);
    strb_grp = 1'b1; sts_clr = 2'b10;
    @(negedge clk);
    strb_grp = 1'b0; sts_clr = 2'b00;
    chk("R7 set wins", 64'(err_udf), 64'd1);
    sts_clr = 2'b10;
    @(negedge clk);
    sts_clr = 2'b00;
    chk("R7 udf cleared", 64'(err_udf), 64'd0);
    chk("R8 irq off", 64'(irq), 64'd0);
    irq_en = 2'b00;
  endtask

  initial begin
    t_reset();
    t_reads();
    t_clamp();
    t_overflow();
    t_underflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule